// File: doc/BRIEF.md
# NOR flash command controller

This block is a synthesizable behavioural model of the control logic inside a byte-wide parallel NOR flash. It sits behind a chip-enable, write-enable and output-enable bus, which it samples on a clock. Write cycles are decoded as unlock-protected commands. Program and erase operations run on a small internal byte array, and their progress is reported in the status byte returned by reads. Pulse and erase durations are replaced by clock-cycle counters.

The array is divided into seven sectors of unequal size. The sizes, counted in units, are 2, 1, 1, 4, 8, 8 and 8. A unit stands for 8K bytes of the full-size device and is `2**UNIT_W` bytes in the model. With `TOP_BOOT=0` the small sectors sit at the low addresses. With `TOP_BOOT=1` the order is reversed. Sectors are numbered 0 to 6 in rising address order.

A separate input protects each sector. A hardware-reset input aborts any running operation. A low-supply input blocks every write. An erase can be suspended so that other sectors can be read or programmed, and resumed afterwards.

Top module: `nor_flash_ctrl`

## Requirements
- R1: After `rst_ni`, every byte reads 0xFF and the controller is in read mode. A read cycle is a clock edge with `ce_ni`=0, `oe_ni`=0 and `we_ni`=1. The data it returns appears on `data_o` after that edge.
- R2: A program command stores (old byte AND written byte), so bits only go from 1 to 0. The command is four write cycles: 0xAA with address low byte 0x55, then 0x55 at 0xAA, then 0xA0 at 0x55, then the data at the target. A write cycle is an edge with `ce_ni`=0, `we_ni`=0 and `oe_ni`=1.
- R3: If a sector's `wp_i` bit is set when a program or erase is requested, that sector's bytes are not changed.
- R4: While busy, a read returns bit 7 equal to the complement of bit 7 of the data being programmed, or 0 during erase. Bits 5:0 read 0.
- R5: Bit 6 inverts on each read made while busy. Once the operation ends, reads return array data.
- R6: A program holds the busy state for `PROG_CYC` cycles after its data write. The controller then returns to read mode on its own.
- R7: Pulling `hw_rst_ni` low aborts a running operation without writing its target and returns the controller to read mode. A new command is then accepted.
- R8: A sector erase is the sequence AA@55, 55@AA, 80@55, AA@55, 55@AA, then 0x30 at an address inside the sector. Further 0x30 writes within `WIN_CYC` cycles of the previous one add their sectors. The erase first sets every selected byte to 0x00, then waits `ERS_CYC` cycles, then fills them with 0xFF. Unselected sectors are untouched.
- R9: Chip erase (same sequence ending with 0x10 at 0x55) erases every unprotected sector.
- R10: A 0xB0 write during an erase suspends it. While suspended, reads at any address return array content, and bytes of a sector whose preprogram pass has finished read 0x00. Non-erasing sectors can be programmed, and the controller then comes back to the suspended state. A 0x30 write resumes the erase and completes it.
- R11: While `lowvcc_i` is 1, write cycles are ignored.
- R12: A write that does not match the next step of a sequence returns the decoder to idle. A 0xF0 write also returns it to idle, so a later command byte without a new unlock does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low; fills the array with 0xFF |
| hw_rst_ni | input | 1 | synchronous abort to read mode, active low |
| ce_ni | input | 1 | chip enable, active low |
| we_ni | input | 1 | write enable, active low |
| oe_ni | input | 1 | output enable, active low |
| addr_i | input | AW (9) | byte address |
| data_i | input | 8 | write data |
| wp_i | input | 7 | per-sector protection, bit n protects sector n |
| lowvcc_i | input | 1 | low-supply write inhibit |
| data_o | output | 8 | registered read data or status |

## Verification
A read result appears on `data_o` one edge after the read cycle. The bench holds each bus cycle from one falling edge to the next and samples at the second falling edge.

A program's data lands `PROG_CYC` edges after the data write. One directed check reads at exactly the last busy edge, and a second reads the edge after the block has left the busy state. All other operations are awaited by pairs of reads until two consecutive results match, which happens only outside the busy state.

The suspend is placed by counting `WIN_CYC` plus one array pass plus a margin, so it lands in the wait phase of the erase.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  localparam int unsigned NUM_SECT = 7;

  typedef enum logic [2:0] {
    ST_READ, ST_PROG, ST_EWIN, ST_PRE, ST_ERS, ST_VFY, ST_SUSP
  } op_st_e;

  // 32 units: bottom boot sizes 2,1,1,4,8,8,8; top boot mirrored
  function automatic logic [2:0] unit_to_sect(input logic [4:0] u, input logic top_boot);
    if (!top_boot) begin
      if (u < 5'd2)       return 3'd0;
      else if (u < 5'd3)  return 3'd1;
      else if (u < 5'd4)  return 3'd2;
      else if (u < 5'd8)  return 3'd3;
      else if (u < 5'd16) return 3'd4;
      else if (u < 5'd24) return 3'd5;
      else                return 3'd6;
    end else begin
      if (u < 5'd8)       return 3'd0;
      else if (u < 5'd16) return 3'd1;
      else if (u < 5'd24) return 3'd2;
      else if (u < 5'd28) return 3'd3;
      else if (u < 5'd29) return 3'd4;
      else if (u < 5'd30) return 3'd5;
      else                return 3'd6;
    end
  endfunction
endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hw_rst_ni,
  input  logic       wr_i,
  input  logic [7:0] addr_lo_i,
  input  logic [7:0] data_i,
  input  logic       accept_i,
  output logic       prog_req_o,
  output logic       chip_req_o,
  output logic       sect_req_o,
  output logic       idle_o
);
  typedef enum logic [2:0] {DS_IDLE, DS_U1, DS_U2, DS_PARM, DS_E1, DS_E2, DS_E3} ds_e;
  ds_e ds_q, ds_d;

  logic at55, atAA;
  assign at55 = addr_lo_i == 8'h55;
  assign atAA = addr_lo_i == 8'hAA;

  always_comb begin
    ds_d       = ds_q;
    prog_req_o = 1'b0;
    chip_req_o = 1'b0;
    sect_req_o = 1'b0;
    if (!accept_i) begin
      ds_d = DS_IDLE;
    end else if (wr_i) begin
      ds_d = DS_IDLE;  // any mismatch falls back
      unique case (ds_q)
        DS_IDLE: if (data_i == 8'hAA && at55) ds_d = DS_U1;
        DS_U1:   if (data_i == 8'h55 && atAA) ds_d = DS_U2;
        DS_U2: begin
          if (data_i == 8'hA0 && at55) ds_d = DS_PARM;
          else if (data_i == 8'h80 && at55) ds_d = DS_E1;
        end
        DS_PARM: prog_req_o = 1'b1;
        DS_E1:   if (data_i == 8'hAA && at55) ds_d = DS_E2;
        DS_E2:   if (data_i == 8'h55 && atAA) ds_d = DS_E3;
        DS_E3: begin
          if (data_i == 8'h10 && at55) chip_req_o = 1'b1;
          else if (data_i == 8'h30) sect_req_o = 1'b1;
        end
        default: ds_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ds_q <= DS_IDLE;
    else if (!hw_rst_ni) ds_q <= DS_IDLE;
    else                 ds_q <= ds_d;
  end

  assign idle_o = ds_q == DS_IDLE;
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  localparam int unsigned NB = 1 << AW;
  logic [7:0] mem_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/nor_op_engine.sv
module nor_op_engine import nor_flash_pkg::*; #(
  parameter int unsigned AW       = 9,
  parameter bit          TOP_BOOT = 1'b0,
  parameter int unsigned PROG_CYC = 8,
  parameter int unsigned WIN_CYC  = 16,
  parameter int unsigned ERS_CYC  = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          dec_idle_i,
  input  logic          prog_req_i,
  input  logic          chip_req_i,
  input  logic          sect_req_i,
  input  logic [NUM_SECT-1:0] wp_i,
  input  logic [7:0]    mem_rdata_i,
  output op_st_e        st_o,
  output logic          accept_o,
  output logic          busy_o,
  output logic          poll_o,
  output logic          pdone_o,
  output logic          pd7_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [7:0]    mem_wdata_o,
  output logic [AW-1:0] mem_raddr_o
);
  localparam int unsigned CMAX = (WIN_CYC > ERS_CYC) ? WIN_CYC : ERS_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned PW   = $clog2(PROG_CYC + 1);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  op_st_e st_q, sus_q;
  logic ret_q;
  logic [NUM_SECT-1:0] emask_q;
  logic [AW-1:0] walk_q, pa_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;
  logic [7:0] pd_q;

  logic [2:0] a_sect, w_sect;
  logic [NUM_SECT-1:0] a_bit, win_mask;
  assign a_sect   = unit_to_sect(addr_i[AW-1 -: 5], TOP_BOOT);
  assign w_sect   = unit_to_sect(walk_q[AW-1 -: 5], TOP_BOOT);
  assign a_bit    = NUM_SECT'(1) << a_sect;
  assign win_mask = emask_q & ~wp_i;

  always_comb begin
    mem_we_o    = 1'b0;
    mem_waddr_o = walk_q;
    mem_wdata_o = 8'h00;
    unique case (st_q)
      ST_PROG: begin
        mem_we_o    = pcnt_q == '0;
        mem_waddr_o = pa_q;
        mem_wdata_o = mem_rdata_i & pd_q;
      end
      ST_PRE: mem_we_o = emask_q[w_sect];
      ST_VFY: begin
        mem_we_o    = emask_q[w_sect];
        mem_wdata_o = 8'hFF;
      end
      default: ;
    endcase
    mem_we_o = mem_we_o & hw_rst_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_READ; sus_q <= ST_ERS; ret_q <= 1'b0; emask_q <= '0;
      walk_q <= '0; pa_q <= '0; pd_q <= 8'h00; cnt_q <= '0; pcnt_q <= '0;
    end else if (!hw_rst_ni) begin
      st_q <= ST_READ; ret_q <= 1'b0; emask_q <= '0; walk_q <= '0;
    end else begin
      unique case (st_q)
        ST_READ: begin
          if (prog_req_i && !wp_i[a_sect]) begin
            pa_q <= addr_i; pd_q <= data_i; pcnt_q <= PW'(PROG_CYC - 1);
            ret_q <= 1'b0; st_q <= ST_PROG;
          end else if (chip_req_i && (~wp_i != '0)) begin
            emask_q <= ~wp_i; walk_q <= '0; st_q <= ST_PRE;
          end else if (sect_req_i) begin
            emask_q <= a_bit; cnt_q <= CW'(WIN_CYC - 1); st_q <= ST_EWIN;
          end
        end
        ST_PROG: begin
          if (pcnt_q == '0) st_q <= ret_q ? ST_SUSP : ST_READ;
          else pcnt_q <= pcnt_q - 1'b1;
        end
        ST_EWIN: begin
          if (wr_i && data_i == 8'h30) begin
            emask_q <= emask_q | a_bit; cnt_q <= CW'(WIN_CYC - 1);
          end else if (cnt_q == '0) begin
            emask_q <= win_mask; walk_q <= '0;
            st_q <= (win_mask != '0) ? ST_PRE : ST_READ;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_PRE, ST_ERS, ST_VFY: begin
          if (wr_i && data_i == 8'hB0) begin
            sus_q <= st_q; st_q <= ST_SUSP;
          end else if (st_q == ST_PRE) begin
            walk_q <= walk_q + 1'b1;
            if (walk_q == LAST) begin st_q <= ST_ERS; cnt_q <= CW'(ERS_CYC - 1); end
          end else if (st_q == ST_ERS) begin
            if (cnt_q == '0) st_q <= ST_VFY;
            else cnt_q <= cnt_q - 1'b1;
          end else begin
            walk_q <= walk_q + 1'b1;
            if (walk_q == LAST) begin st_q <= ST_READ; emask_q <= '0; end
          end
        end
        ST_SUSP: begin
          if (wr_i && data_i == 8'h30 && dec_idle_i) st_q <= sus_q;
          else if (prog_req_i && !wp_i[a_sect] && !emask_q[a_sect]) begin
            pa_q <= addr_i; pd_q <= data_i; pcnt_q <= PW'(PROG_CYC - 1);
            ret_q <= 1'b1; st_q <= ST_PROG;
          end
        end
        default: st_q <= ST_READ;
      endcase
    end
  end

  assign st_o        = st_q;
  assign accept_o    = st_q == ST_READ || st_q == ST_SUSP;
  assign busy_o      = !accept_o;
  assign poll_o      = (st_q == ST_PROG) ? ~pd_q[7] : 1'b0;
  assign pdone_o     = pcnt_q == '0;
  assign pd7_o       = pd_q[7];
  assign mem_raddr_o = pa_q;
endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl import nor_flash_pkg::*; #(
  parameter int unsigned UNIT_W   = 4,
  parameter bit          TOP_BOOT = 1'b0,
  parameter int unsigned PROG_CYC = 8,
  parameter int unsigned WIN_CYC  = 16,
  parameter int unsigned ERS_CYC  = 32,
  localparam int unsigned AW      = UNIT_W + 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic [6:0]    wp_i,
  input  logic          lowvcc_i,
  output logic [7:0]    data_o
);
  logic wr_stb, rd_stb;
  assign wr_stb = !ce_ni && !we_ni && oe_ni && !lowvcc_i;
  assign rd_stb = !ce_ni && !oe_ni && we_ni;

  logic prog_req, chip_req, sect_req, dec_idle, accept, busy, poll, pdone, pd7;
  logic mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0] mem_wdata, rdata_a, rdata_b;
  op_st_e st;

  nor_cmd_seq i_seq (
    .clk_i, .rst_ni, .hw_rst_ni, .wr_i(wr_stb), .addr_lo_i(addr_i[7:0]),
    .data_i, .accept_i(accept), .prog_req_o(prog_req), .chip_req_o(chip_req),
    .sect_req_o(sect_req), .idle_o(dec_idle)
  );

  nor_op_engine #(
    .AW(AW), .TOP_BOOT(TOP_BOOT), .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .ERS_CYC(ERS_CYC)
  ) i_eng (
    .clk_i, .rst_ni, .hw_rst_ni, .wr_i(wr_stb), .addr_i, .data_i,
    .dec_idle_i(dec_idle), .prog_req_i(prog_req), .chip_req_i(chip_req),
    .sect_req_i(sect_req), .wp_i, .mem_rdata_i(rdata_b), .st_o(st),
    .accept_o(accept), .busy_o(busy), .poll_o(poll), .pdone_o(pdone), .pd7_o(pd7),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .mem_raddr_o(mem_raddr)
  );

  nor_array #(.AW(AW)) i_arr (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_a_i(addr_i), .rdata_a_o(rdata_a), .raddr_b_i(mem_raddr), .rdata_b_o(rdata_b)
  );

  logic tog_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      data_o <= 8'h00;
    end else if (rd_stb) begin
      if (busy) begin
        data_o <= {poll, tog_q, 6'b000000};
        tog_q  <= ~tog_q;
      end else begin
        data_o <= rdata_a;
      end
    end
  end
endmodule

// File: rtl/nor_flash_ctrl_chk.sv
module nor_flash_ctrl_chk import nor_flash_pkg::*; (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hw_rst_ni,
  input logic       lowvcc_i,
  input logic       rd_i,
  input logic       busy_i,
  input op_st_e     st_i,
  input logic       pdone_i,
  input logic       pd7_i,
  input logic [7:0] data_i,
  input logic       mem_we_i,
  input logic [7:0] mem_wdata_i
);
  logic prev_busy_rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_busy_rd_q <= 1'b0;
    else         prev_busy_rd_q <= rd_i && busy_i;
  end

  AST_HWRST_TO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_rst_ni |=> st_i == ST_READ);  // R7
  AST_LOWVCC_STAYS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowvcc_i && hw_rst_ni && st_i == ST_READ |=> st_i == ST_READ);  // R11
  AST_POLL_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && st_i == ST_PROG |=> data_i[7] == !$past(pd7_i) && data_i[5:0] == 6'd0);  // R4
  AST_TOGGLE_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_busy_rd_q && rd_i && busy_i |=> data_i[6] != $past(data_i[6]));  // R5
  AST_PROG_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_PROG && pdone_i |=> st_i == ST_READ || st_i == ST_SUSP);  // R6
  AST_PREPROG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i && st_i == ST_PRE |-> mem_wdata_i == 8'h00);  // R8
  AST_FILL_ERASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i && st_i == ST_VFY |-> mem_wdata_i == 8'hFF);  // R8
endmodule

bind nor_flash_ctrl nor_flash_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hw_rst_ni(hw_rst_ni), .lowvcc_i(lowvcc_i),
  .rd_i(rd_stb), .busy_i(busy), .st_i(st), .pdone_i(pdone), .pd7_i(pd7),
  .data_i(data_o), .mem_we_i(mem_we), .mem_wdata_i(mem_wdata)
);

// File: tb/test_nor_flash_ctrl.sv
module test_nor_flash_ctrl;
  localparam int TCLK = 10;
  localparam int UNIT_W = 4;
  localparam int AW = UNIT_W + 5;
  localparam int NB = 1 << AW;
  localparam int PROG_CYC = 8;
  localparam int WIN_CYC = 16;
  localparam int ERS_CYC = 32;
  localparam int SSTART [7] = '{0, 2, 3, 4, 8, 16, 24};

  logic clk = 1'b0, rst_n = 1'b0, hw_rst_n = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lowvcc = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00, dout;
  logic [6:0] wp = 7'd0;
  logic [7:0] mdl [NB];
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  nor_flash_ctrl #(.UNIT_W(UNIT_W), .TOP_BOOT(1'b0), .PROG_CYC(PROG_CYC),
                   .WIN_CYC(WIN_CYC), .ERS_CYC(ERS_CYC)) i_nor_flash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_ni(hw_rst_n), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .data_i(din), .wp_i(wp), .lowvcc_i(lowvcc), .data_o(dout)
  );

  function automatic int bsect(input int a);
    for (int s = 6; s >= 0; s--) if ((a >> UNIT_W) >= SSTART[s]) return s;
    return 0;
  endfunction
  function automatic logic [AW-1:0] base(input int s);
    return AW'(SSTART[s] << UNIT_W);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = dout; ce_n = 1'b1; oe_n = 1'b1;
  endtask
  task automatic unlock();
    wr(AW'(9'h155), 8'hAA); wr(AW'(9'h0AA), 8'h55);
  endtask
  task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); wr(AW'(9'h155), 8'hA0); wr(a, d);
  endtask
  task automatic wait_done(input string tag);
    logic [7:0] v1, v2;
    for (int i = 0; i < 3000; i++) begin
      rd('0, v1); rd('0, v2);
      if (v1 == v2) return;
    end
    chk({tag, " completion"}, 8'h00, 8'h01);
  endtask
  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    prog_seq(a, d);
    if (!wp[bsect(int'(a))]) mdl[a] = mdl[a] & d;
    wait_done("R2");
  endtask
  task automatic erase_seq_head();
    unlock(); wr(AW'(9'h155), 8'h80); unlock();
  endtask
  task automatic erase_model(input logic [6:0] m);
    for (int a = 0; a < NB; a++) if (m[bsect(a)] && !wp[bsect(a)]) mdl[a] = 8'hFF;
  endtask
  task automatic check_all(input string tag);
    logic [7:0] v;
    int bad = 0, fa = 0;
    logic [7:0] fv = 8'h00;
    for (int a = 0; a < NB; a++) begin
      rd(AW'(a), v);
      if (v !== mdl[a]) begin
        if (bad == 0) begin fa = a; fv = v; end
        bad++;
      end
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: %0d bytes differ, addr %0d actual %h expected %h", tag, bad, fa, fv, mdl[fa]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    logic [AW-1:0] ra;
    logic [7:0] rdat;
    void'($urandom(32'd4711));
    for (int a = 0; a < NB; a++) mdl[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd('0, v); chk("R1 first byte", v, 8'hFF);
    check_all("R1 erased array");

    // R2/R4/R5 program with status reads
    prog_seq(AW'(9'h010), 8'hA5);
    rd('0, v); chk("R4 poll bit7/low bits", {v[7], 2'b00, v[5:0]}, 8'h00);
    rd('0, v2); chk("R5 toggle", {7'd0, v2[6] ^ v[6]}, 8'h01);
    mdl[9'h010] = 8'hA5;
    wait_done("R6");
    rd(AW'(9'h010), v); chk("R2 program", v, 8'hA5);
    rd(AW'(9'h010), v2); chk("R5 no toggle when idle", v2, v);

    // R6 exact timing, R2 only clears bits
    prog_seq(AW'(9'h010), 8'h5A);
    mdl[9'h010] = 8'h00;
    repeat (PROG_CYC - 2) @(negedge clk);
    rd(AW'(9'h010), v); chk("R6 last busy read", {v[7], v[5:0]}, 7'b1000000);
    rd(AW'(9'h010), v); chk("R6 back to read mode / R2 and", v, 8'h00);

    // R12 broken unlock and reset command
    wr(AW'(9'h155), 8'hAA); wr(AW'(9'h0AB), 8'h55); wr(AW'(9'h155), 8'hA0); wr(base(5) + 7, 8'h00);
    repeat (PROG_CYC + 2) @(negedge clk);
    rd(base(5) + 7, v); chk("R12 broken unlock", v, mdl[base(5) + 7]);
    unlock(); wr('0, 8'hF0); wr(AW'(9'h155), 8'hA0); wr(base(5) + 8, 8'h00);
    repeat (PROG_CYC + 2) @(negedge clk);
    rd(base(5) + 8, v); chk("R12 reset command", v, mdl[base(5) + 8]);

    // R11 low supply
    lowvcc = 1'b1;
    prog_seq(base(5) + 9, 8'h00);
    lowvcc = 1'b0;
    rd(base(5) + 9, v); chk("R11 inhibit immediate", v, mdl[base(5) + 9]);
    repeat (PROG_CYC + 2) @(negedge clk);
    rd(base(5) + 9, v); chk("R11 inhibit later", v, mdl[base(5) + 9]);

    // R7 hardware reset aborts a program
    prog_seq(base(5) + 10, 8'h00);
    @(negedge clk); hw_rst_n = 1'b0;
    @(negedge clk); hw_rst_n = 1'b1;
    rd(base(5) + 10, v); chk("R7 aborted byte", v, mdl[base(5) + 10]);
    rd(base(5) + 10, v2); chk("R7 read mode", v2, mdl[base(5) + 10]);
    prog(base(5) + 10, 8'h0F);
    rd(base(5) + 10, v); chk("R7 command after abort", v, mdl[base(5) + 10]);

    // R3 directed
    wp = 7'b0000100;
    prog(base(2) + 1, 8'h00);
    rd(base(2) + 1, v); chk("R3 protected program", v, 8'hFF);

    // random programs, R2/R3
    for (int i = 0; i < 40; i++) begin
      ra = AW'($urandom_range(NB - 1, 0));
      rdat = 8'($urandom);
      prog(ra, rdat);
      rd(ra, v); chk("R2/R3 random program", v, mdl[ra]);
    end

    // prefill each sector
    wp = 7'd0;
    for (int s = 0; s < 7; s++) prog(base(s) + 3, 8'h00);

    // R8 multi-sector erase with one protected sector
    wp = 7'b0000100;
    erase_seq_head();
    wr(base(1), 8'h30); wr(base(2) + 2, 8'h30); wr(base(5) + 1, 8'h30);
    erase_model(7'b0100110);
    wait_done("R8");
    check_all("R8/R3 sector erase");

    // R10 suspend during wait phase
    erase_seq_head();
    wr(base(4), 8'h30);
    repeat (WIN_CYC + NB + 10) @(negedge clk);
    wr('0, 8'hB0);
    rd(base(4), v); chk("R10 preprogrammed byte", v, 8'h00);
    rd(base(6) + 3, v); chk("R10 read other sector", v, mdl[base(6) + 3]);
    prog(base(6) + 5, 8'h3C);
    rd(base(6) + 5, v); chk("R10 program while suspended", v, mdl[base(6) + 5]);
    wr('0, 8'h30);
    erase_model(7'b0010000);
    wait_done("R10");
    check_all("R10 resumed erase");

    // R9 chip erase with sector 0 protected
    wp = 7'd0;
    prog(base(0) + 6, 8'h12);
    wp = 7'b0000001;
    erase_seq_head();
    wr(AW'(9'h155), 8'h10);
    erase_model(7'b1111111);
    wait_done("R9");
    check_all("R9/R3 chip erase");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule